// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block runs a self-scanning linear image sensor and gathers the pixel samples that the sensor produces. It makes a free-running pixel clock from a programmable divider of the system clock. On a start request it sends the sensor two start pulses. The spacing between their rising edges sets the integration time. The scan that follows the first pulse only flushes the sensor and is thrown away. The scan that follows the second pulse is the one that is kept.

While that second scan is open, every falling edge of the sensor's per-pixel trigger raises a one-cycle conversion request to an external ADC. Each sample the ADC returns is written to consecutive buffer addresses. The sensor's active-low end-of-scan edge closes the window. The number of pixels is not fixed: the block counts what it actually stored, so the same logic serves sensors of 256, 512, 1024 or 2048 pixels. When the last sample is in, it pulses line-done and holds the count. A mode output tells the sensor whether to sum each column into one value (binning) or to scan every pixel. In the scanning mode, rows are separated by runs of blank pixels.

The trigger and end-of-scan inputs are asynchronous and pass through synchronizer chains. Two sticky flags report faults: one for an integration interval too short to let the flush scan finish, and one for a line longer than the buffer.

Top module: `lsens_readout`

## Requirements
- R1: `pclk_o` toggles without stopping, and each of its half periods lasts `pclk_div_i`+1 system clock cycles.
- R2: A `start_req_i` seen while the block is idle produces two `st_o` pulses, each high for ST_W cycles. When end-of-scan of the flush scan has been seen in time, their rising edges are exactly `integ_i` cycles apart. A `start_req_i` during an acquisition has no effect.
- R3: Trigger edges during the flush scan, and anything else before the second `st_o` rising edge, cause no conversion and no write.
- R4: Inside the window, each falling edge of `trig_i` gives exactly one `conv_o` pulse. The window runs from the second `st_o` rising edge to the synchronized falling edge of `eos_n_i`. Trigger edges after that falling edge give none.
- R5: Each `adc_valid_i` that answers an outstanding conversion writes `adc_data_i` through `wr_en_o`/`wr_addr_o`/`wr_data_o`, at addresses 0, 1, 2, … in order. Only one conversion is outstanding at a time.
- R6: `pix_count_o` equals the number of samples written in the line, for any length up to MAX_PIX. It is cleared at the second `st_o` rising edge and otherwise holds its value, including across the next request.
- R7: `line_done_o` is a single-cycle pulse, one per line. It comes after end-of-scan and after the last write. When a conversion is still outstanding at end-of-scan, the pulse comes in the cycle right after that final write.
- R8: Once MAX_PIX samples are stored, further samples are not written and `pix_count_o` stays at MAX_PIX. `ovf_o` is set and stays set until the next accepted start request.
- R9: If the integration interval runs out before end-of-scan of the flush scan, `short_int_o` is set and the second pulse waits until that end-of-scan. The flag is cleared by the next accepted start request.
- R10: `mode_sel_o` takes the value of `binning_i` when a start request is accepted (1 = binning, 0 = per-pixel scanning). It stays stable for the rest of that acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pclk_div_i | input | DIV_W | Pixel clock half period minus one, in system cycles |
| integ_i | input | INT_W | Spacing of the two start pulses in system cycles (> ST_W) |
| start_req_i | input | 1 | Request one integrate-and-read acquisition |
| binning_i | input | 1 | Readout mode requested for the next acquisition |
| trig_i | input | 1 | Sensor per-pixel trigger, asynchronous |
| eos_n_i | input | 1 | Sensor end-of-scan, active low, asynchronous |
| adc_valid_i | input | 1 | ADC sample ready |
| adc_data_i | input | DATA_W | ADC sample |
| pclk_o | output | 1 | Pixel clock to the sensor |
| st_o | output | 1 | Start pulse to the sensor |
| mode_sel_o | output | 1 | Readout mode to the sensor |
| conv_o | output | 1 | One-cycle conversion request to the ADC |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | clog2(MAX_PIX) | Buffer write address |
| wr_data_o | output | DATA_W | Buffer write data |
| pix_count_o | output | clog2(MAX_PIX+1) | Pixels captured in the current or last line |
| line_done_o | output | 1 | One-cycle end-of-line pulse |
| short_int_o | output | 1 | Sticky: integration shorter than the flush scan |
| ovf_o | output | 1 | Sticky: line longer than the buffer |

## Verification
Some properties are checked on every cycle. The pixel clock must hold between divider terminal counts. Conversions may appear only while the window was open. The count must step by one with each write, at the matching address. The overflow flag must stay set, and no write may follow it. The done pulse must last one cycle, and the mode must stay fixed during an acquisition. Other behaviour needs whole sensor scans, which only the bench scenarios can show. These cover the exact start-pulse spacing, the discarding of the flush scan, the line lengths 256 to 2050, the flag clearing on the next request, and the done pulse that waits on a late final sample.

// File: rtl/lsens_pkg.sv
package lsens_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FLUSH_ST,
      SQ_INTEG,
      SQ_READ_ST,
      SQ_READ,
      SQ_DRAIN
   } seq_state_t;
endpackage

// File: rtl/lsens_pclk_div.sv
module lsens_pclk_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_i,
   output logic             pclk_o
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pclk_o <= 1'b0;
      end else if (cnt_q >= half_i) begin
         cnt_q  <= '0;
         pclk_o <= ~pclk_o;
      end else begin
         cnt_q  <= cnt_q + DIV_W'(1);
      end
   end

   // R1: no toggle before the terminal count
   p_pclk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q < half_i) |=> (pclk_o == $past(pclk_o)));
endmodule

// File: rtl/lsens_fall_sync.sv
module lsens_fall_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_sync
         $error("STAGES must be at least 2");
      end
   endgenerate

   // bits 0..STAGES-1 synchronize, bit STAGES holds the previous value
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], async_i};
   end

   assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/lsens_seq_fsm.sv
module lsens_seq_fsm
   import lsens_pkg::*;
#(
   parameter int ST_W  = 4,
   parameter int INT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req_i,
   input  logic [INT_W-1:0] integ_i,
   input  logic             binning_i,
   input  logic             eos_fall_i,
   input  logic             busy_i,
   output logic             st_o,
   output logic             mode_sel_o,
   output logic             win_o,
   output logic             start_acc_o,
   output logic             cnt_clr_o,
   output logic             line_done_o,
   output logic             short_int_o
);
   localparam int STC_W = $clog2(ST_W + 1);

   generate
      if (ST_W < 1) begin : g_bad_st
         $error("ST_W must be at least 1");
      end
   endgenerate

   seq_state_t        state_q;
   logic [STC_W-1:0]  st_cnt_q;
   logic [INT_W-1:0]  int_cnt_q;
   logic              eos_seen_q;
   logic              expired;

   assign expired     = (int_cnt_q >= integ_i);
   assign start_acc_o = (state_q == SQ_IDLE) && start_req_i;
   assign cnt_clr_o   = (state_q == SQ_INTEG) && expired && eos_seen_q;
   assign st_o        = (state_q == SQ_FLUSH_ST) || (state_q == SQ_READ_ST);
   assign win_o       = (state_q == SQ_READ_ST) || (state_q == SQ_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         st_cnt_q    <= '0;
         int_cnt_q   <= '0;
         eos_seen_q  <= 1'b0;
         mode_sel_o  <= 1'b0;
         short_int_o <= 1'b0;
         line_done_o <= 1'b0;
      end else begin
         line_done_o <= 1'b0;
         if ((state_q == SQ_FLUSH_ST) || (state_q == SQ_INTEG)) begin
            if (int_cnt_q != '1) int_cnt_q <= int_cnt_q + INT_W'(1);
            if (eos_fall_i) eos_seen_q <= 1'b1;
         end
         case (state_q)
            SQ_IDLE: if (start_req_i) begin
               state_q     <= SQ_FLUSH_ST;
               st_cnt_q    <= STC_W'(1);
               int_cnt_q   <= INT_W'(1);
               eos_seen_q  <= 1'b0;
               short_int_o <= 1'b0;
               mode_sel_o  <= binning_i;
            end
            SQ_FLUSH_ST: begin
               if (st_cnt_q >= STC_W'(ST_W)) state_q <= SQ_INTEG;
               else st_cnt_q <= st_cnt_q + STC_W'(1);
            end
            SQ_INTEG: if (expired) begin
               if (eos_seen_q) begin
                  state_q  <= SQ_READ_ST;
                  st_cnt_q <= STC_W'(1);
               end else begin
                  short_int_o <= 1'b1;
               end
            end
            SQ_READ_ST: begin
               if (eos_fall_i) state_q <= SQ_DRAIN;
               else if (st_cnt_q >= STC_W'(ST_W)) state_q <= SQ_READ;
               else st_cnt_q <= st_cnt_q + STC_W'(1);
            end
            SQ_READ: if (eos_fall_i) state_q <= SQ_DRAIN;
            SQ_DRAIN: if (!busy_i) begin
               line_done_o <= 1'b1;
               state_q     <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R10: mode fixed while an acquisition runs
   p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE) |=> $stable(mode_sel_o));
   // R9: second pulse held back until the flush scan has ended
   p_hold_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_INTEG && !eos_seen_q) |=> (state_q != SQ_READ_ST));
   // R7: done is a single-cycle pulse and never precedes a pending sample
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_done_o |=> !line_done_o);
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_done_o |-> !busy_i);
endmodule

// File: rtl/lsens_capture.sv
module lsens_capture #(
   parameter int DATA_W  = 12,
   parameter int MAX_PIX = 2048
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         trig_fall_i,
   input  logic                         win_i,
   input  logic                         cnt_clr_i,
   input  logic                         start_acc_i,
   input  logic                         adc_valid_i,
   input  logic [DATA_W-1:0]            adc_data_i,
   output logic                         conv_o,
   output logic                         busy_o,
   output logic                         wr_en_o,
   output logic [$clog2(MAX_PIX)-1:0]   wr_addr_o,
   output logic [DATA_W-1:0]            wr_data_o,
   output logic [$clog2(MAX_PIX+1)-1:0] pix_count_o,
   output logic                         ovf_o
);
   localparam int AW = $clog2(MAX_PIX);
   localparam int CW = $clog2(MAX_PIX + 1);

   generate
      if (MAX_PIX < 2) begin : g_bad_depth
         $error("MAX_PIX must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic req;
   assign req = trig_fall_i & win_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_o      <= 1'b0;
         busy_o      <= 1'b0;
         wr_en_o     <= 1'b0;
         wr_addr_o   <= '0;
         wr_data_o   <= '0;
         pix_count_o <= '0;
         ovf_o       <= 1'b0;
      end else begin
         conv_o  <= req;
         wr_en_o <= 1'b0;
         if (req)              busy_o <= 1'b1;
         else if (adc_valid_i) busy_o <= 1'b0;
         if (start_acc_i) ovf_o <= 1'b0;
         if (cnt_clr_i) begin
            pix_count_o <= '0;
         end else if (adc_valid_i && busy_o) begin
            if (pix_count_o < CW'(MAX_PIX)) begin
               wr_en_o     <= 1'b1;
               wr_addr_o   <= AW'(pix_count_o);
               wr_data_o   <= adc_data_i;
               pix_count_o <= pix_count_o + CW'(1);
            end else begin
               ovf_o <= 1'b1;
            end
         end
      end
   end

   // R4: a conversion only follows an open window
   p_conv_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_o |-> $past(win_i));
   // R5 / R6: each write advances the count by one at the matching address
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (pix_count_o == $past(pix_count_o) + CW'(1)));
   p_addr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_addr_o == AW'($past(pix_count_o))));
   // R8: overflow is sticky and blocks writes
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !start_acc_i) |=> ovf_o);
   p_no_overflow_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> !wr_en_o);
endmodule

// File: rtl/lsens_readout.sv
module lsens_readout #(
   parameter int DIV_W       = 16,
   parameter int INT_W       = 24,
   parameter int ST_W        = 4,
   parameter int DATA_W      = 12,
   parameter int MAX_PIX     = 2048,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DIV_W-1:0]             pclk_div_i,
   input  logic [INT_W-1:0]             integ_i,
   input  logic                         start_req_i,
   input  logic                         binning_i,
   input  logic                         trig_i,
   input  logic                         eos_n_i,
   input  logic                         adc_valid_i,
   input  logic [DATA_W-1:0]            adc_data_i,
   output logic                         pclk_o,
   output logic                         st_o,
   output logic                         mode_sel_o,
   output logic                         conv_o,
   output logic                         wr_en_o,
   output logic [$clog2(MAX_PIX)-1:0]   wr_addr_o,
   output logic [DATA_W-1:0]            wr_data_o,
   output logic [$clog2(MAX_PIX+1)-1:0] pix_count_o,
   output logic                         line_done_o,
   output logic                         short_int_o,
   output logic                         ovf_o
);
   logic trig_fall, eos_fall, win, start_acc, cnt_clr, busy;

   lsens_pclk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .half_i(pclk_div_i), .pclk_o(pclk_o));

   lsens_fall_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .async_i(trig_i), .fall_o(trig_fall));

   lsens_fall_sync #(.STAGES(SYNC_STAGES)) u_eos_sync (
      .clk(clk), .rst_n(rst_n), .async_i(eos_n_i), .fall_o(eos_fall));

   lsens_seq_fsm #(.ST_W(ST_W), .INT_W(INT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_req_i(start_req_i), .integ_i(integ_i),
      .binning_i(binning_i), .eos_fall_i(eos_fall), .busy_i(busy),
      .st_o(st_o), .mode_sel_o(mode_sel_o), .win_o(win),
      .start_acc_o(start_acc), .cnt_clr_o(cnt_clr),
      .line_done_o(line_done_o), .short_int_o(short_int_o));

   lsens_capture #(.DATA_W(DATA_W), .MAX_PIX(MAX_PIX)) u_cap (
      .clk(clk), .rst_n(rst_n), .trig_fall_i(trig_fall), .win_i(win),
      .cnt_clr_i(cnt_clr), .start_acc_i(start_acc),
      .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i),
      .conv_o(conv_o), .busy_o(busy), .wr_en_o(wr_en_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .pix_count_o(pix_count_o), .ovf_o(ovf_o));

   // R3: nothing reaches the buffer outside the read window
   p_no_flush_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o && !win) |-> !conv_o);
endmodule

// File: tb/sim_lsens_readout.sv
module sim_lsens_readout;
   localparam int CLK_PERIOD = 10;
   localparam int MAXP = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pclk_div_i = 16'd0;
   logic [23:0] integ_i = 24'd200;
   logic        start_req_i = 1'b0, binning_i = 1'b0;
   logic        trig_i = 1'b1, eos_n_i = 1'b1;
   logic        adc_valid_i = 1'b0;
   logic [11:0] adc_data_i = '0;
   logic        pclk_o, st_o, mode_sel_o, conv_o, wr_en_o;
   logic [10:0] wr_addr_o;
   logic [11:0] wr_data_o;
   logic [11:0] pix_count_o;
   logic        line_done_o, short_int_o, ovf_o;

   lsens_readout u0 (
      .clk(clk), .rst_n(rst_n), .pclk_div_i(pclk_div_i), .integ_i(integ_i),
      .start_req_i(start_req_i), .binning_i(binning_i), .trig_i(trig_i),
      .eos_n_i(eos_n_i), .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i),
      .pclk_o(pclk_o), .st_o(st_o), .mode_sel_o(mode_sel_o), .conv_o(conv_o),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .pix_count_o(pix_count_o), .line_done_o(line_done_o),
      .short_int_o(short_int_o), .ovf_o(ovf_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // ADC model: sample ready four cycles after a request
   int lat = 0, adc_seq = 0;
   int exp_q[$];
   always @(negedge clk) begin
      adc_valid_i <= 1'b0;
      if (conv_o) lat = 3;
      else if (lat == 1) begin
         automatic logic [11:0] d = 12'((adc_seq * 37 + 5) % 4096);
         adc_valid_i <= 1'b1;
         adc_data_i  <= d;
         exp_q.push_back(int'(d));
         adc_seq++;
         lat = 0;
      end else if (lat > 0) lat = lat - 1;
   end

   // per-clock reference: pixel clock half period (R1)
   logic pclk_prev = 1'b0;
   int   since = 0;
   bit   seen_tog = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         seen_tog = 0; since = 0; pclk_prev = 1'b0;
      end else begin
         since++;
         if (pclk_o !== pclk_prev) begin
            if (seen_tog) chk(since == int'(pclk_div_i) + 1, "R1 pclk half period",
                              since, int'(pclk_div_i) + 1);
            seen_tog = 1; since = 0;
         end
         pclk_prev = pclk_o;
      end
   end

   // per-clock monitors of the line
   int  st_rise_q[$];
   int  conv_n = 0, wr_n = 0, exp_addr = 0, last_wr = 0, done_n = 0, done_cyc = 0;
   logic st_prev = 1'b0, done_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (st_o && !st_prev) st_rise_q.push_back(cyc);
         if (conv_o) conv_n++;
         if (line_done_o) begin done_n++; done_cyc = cyc; end
         if (line_done_o && done_prev) chk(0, "R7 done wider than one cycle", 2, 1);
         if (wr_en_o) begin
            chk(int'(wr_addr_o) == exp_addr, "R5 write address", int'(wr_addr_o), exp_addr);
            if (exp_q.size() == 0) chk(0, "R5 write without sample", 1, 0);
            else begin
               automatic int e = exp_q.pop_front();
               chk(int'(wr_data_o) == e, "R5 write data", int'(wr_data_o), e);
            end
            exp_addr++; wr_n++; last_wr = cyc;
         end
      end
      st_prev = st_o; done_prev = line_done_o;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic trig_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         trig_i = 1'b0; tick(4);
         trig_i = 1'b1; tick(4);
      end
   endtask

   task automatic run_line(input int npix, input int integ, input bit bin,
                           input bit tight, input bit exp_short);
      int s0, s1, expw;
      exp_q.delete(); st_rise_q.delete();
      conv_n = 0; wr_n = 0; exp_addr = 0; done_n = 0;
      integ_i = 24'(integ); binning_i = bin;
      start_req_i = 1'b1; tick(1); start_req_i = 1'b0;
      chk(ovf_o == 1'b0, "R8 overflow cleared by request", int'(ovf_o), 0);
      chk(short_int_o == 1'b0, "R9 short flag cleared by request", int'(short_int_o), 0);
      chk(mode_sel_o == bin, "R10 mode latched", int'(mode_sel_o), int'(bin));
      while (st_rise_q.size() < 1) tick(1);
      while (st_o) tick(1);
      trig_pulses(10);                        // flush scan
      eos_n_i = 1'b0; tick(6); eos_n_i = 1'b1;
      while (st_rise_q.size() < 2) tick(1);
      chk(conv_n == 0 && wr_n == 0, "R3 flush scan discarded", conv_n + wr_n, 0);
      chk(pix_count_o == 0, "R6 count cleared at second pulse", int'(pix_count_o), 0);
      s0 = st_rise_q[0]; s1 = st_rise_q[1];
      if (exp_short) begin
         chk(short_int_o == 1'b1, "R9 short flag", int'(short_int_o), 1);
         chk(s1 - s0 > integ, "R9 second pulse held", s1 - s0, integ + 1);
      end else begin
         chk(short_int_o == 1'b0, "R9 no short flag", int'(short_int_o), 0);
         chk(s1 - s0 == integ, "R2 start pulse spacing", s1 - s0, integ);
      end
      while (st_o) tick(1);
      // request and mode change during acquisition must be ignored (R2, R10)
      binning_i = ~bin; start_req_i = 1'b1; tick(1); start_req_i = 1'b0;
      trig_pulses(tight ? npix - 1 : npix);
      if (tight) begin
         trig_i = 1'b0; eos_n_i = 1'b0; tick(4); trig_i = 1'b1; tick(4);
      end else begin
         eos_n_i = 1'b0; tick(4);
      end
      trig_pulses(3);                         // after end-of-scan
      eos_n_i = 1'b1; tick(20);
      expw = (npix > MAXP) ? MAXP : npix;
      chk(st_rise_q.size() == 2, "R2 request ignored while busy", st_rise_q.size(), 2);
      chk(mode_sel_o == bin, "R10 mode stable", int'(mode_sel_o), int'(bin));
      chk(conv_n == npix, "R4 one conversion per trigger edge", conv_n, npix);
      chk(wr_n == expw, "R5 samples written", wr_n, expw);
      chk(int'(pix_count_o) == expw, "R6 captured count", int'(pix_count_o), expw);
      chk(ovf_o == (npix > MAXP), "R8 overflow flag", int'(ovf_o), int'(npix > MAXP));
      chk(done_n == 1, "R7 one done pulse", done_n, 1);
      chk(done_cyc > last_wr, "R7 done after last write", done_cyc, last_wr + 1);
      if (tight) chk(done_cyc == last_wr + 1, "R7 done follows final write",
                     done_cyc, last_wr + 1);
      tick(30);
      chk(int'(pix_count_o) == expw, "R6 count held", int'(pix_count_o), expw);
   endtask

   initial begin
      // fastest divider first, then a slower one after a fresh reset
      pclk_div_i = 16'd0;
      tick(3); rst_n = 1'b1; tick(20);
      rst_n = 1'b0; pclk_div_i = 16'd3; tick(2);
      chk(st_o == 0 && conv_o == 0 && wr_en_o == 0 && line_done_o == 0,
          "R2 reset outputs idle", int'(st_o) + int'(conv_o) + int'(wr_en_o), 0);
      chk(pix_count_o == 0 && ovf_o == 0 && short_int_o == 0,
          "R8 reset flags clear", int'(pix_count_o) + int'(ovf_o), 0);
      rst_n = 1'b1; tick(5);
      run_line(256,  200, 1'b1, 1'b0, 1'b0);
      run_line(1024, 150, 1'b0, 1'b1, 1'b0);
      run_line(2048, 200, 1'b1, 1'b1, 1'b0);
      run_line(2050, 200, 1'b0, 1'b0, 1'b0);
      run_line(512,  40,  1'b1, 1'b0, 1'b1);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule